// File: doc/BRIEF.md
# Dual-Register Output Cell for a Sum-of-Products Logic Device

This block is one output cell of a small sum-of-products logic device. The AND/OR array computes two sum terms outside the block and hands them in. Inside the cell there are two storage elements. Each one can be set up as a plain data register or as a toggle register. Each one picks its own clock, either the shared clock pin or a clock built from its own product term. Each one has its own asynchronous clear product term. A single preset term loads ones into both registers at their next clock edge. A test load port can write any pattern into the registers.

The two sum terms can be merged into one function by an OR, or kept apart. When they are kept apart, sum term 0 drives the pin path and sum term 1 drives the second register, which has no pin of its own. The pin shows either the first register or the combinational value of the pin path, and an enable product term gates it. Both register outputs always return to the array on feedback lines. These lines are separate from the pin, so the pin can work as an input while the registers stay buried.

Top module: `pld_macrocell_pair`

## Requirements
- R1: A register in data mode (`cfg_ttype[i]=0`) takes its data input at its selected clock edge. The data input of register 0 is `sum0|sum1` when `cfg_combined=1` and `sum0` when `cfg_combined=0`. The data input of register 1 is always `sum1`.
- R2: A register in toggle mode (`cfg_ttype[i]=1`) inverts its state at its clock edge when its data input is 1, and holds its state when the data input is 0.
- R3: With `cfg_pinclk[i]=1`, register i is clocked only by the rising edge of `clk_pin`. With `cfg_pinclk[i]=0`, it is clocked only by the rising edge of `pt_clk[i]`. The clock that is not selected has no effect.
- R4: `pt_arst[i]=1` or `rst_n=0` clears `fb[i]` at once, with no clock edge needed. The register stays 0 while the clear is held, even if a test load or a preset is requested.
- R5: `pt_spreset=1` at a register's clock edge loads 1 into that register. This overrides the data and toggle update.
- R6: `preload_en=1` at a register's clock edge loads `preload_val[i]`. This overrides both the preset and the normal update.
- R7: With `pt_oe=1`, `pad` carries `fb[0]` when `cfg_reg_out=1`, and the register-0 data input (combinational) when `cfg_reg_out=0`. With `pt_oe=0`, the cell releases `pad`, and `pin_in` follows the level driven from outside.
- R8: `fb[0]` and `fb[1]` follow the register state no matter how the pin is enabled. A level driven onto `pad` from outside never enters either register.
- R9: After `rst_n` is released, both feedback outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Power-on clear, active low, asynchronous |
| clk_pin | input | 1 | Shared clock pin |
| pt_clk | input | 2 | Product-term clock, one per register |
| pt_arst | input | 2 | Asynchronous clear term, one per register, active high |
| sum0 | input | 1 | First sum term |
| sum1 | input | 1 | Second sum term |
| pt_spreset | input | 1 | Shared synchronous preset term |
| pt_oe | input | 1 | Output enable term for the pin |
| preload_en | input | 1 | Test load enable |
| preload_val | input | 2 | Test load value, bit i goes to register i |
| cfg_ttype | input | 2 | 1 selects toggle mode, 0 selects data mode, one bit per register |
| cfg_pinclk | input | 2 | 1 selects the clock pin, 0 selects the product-term clock |
| cfg_combined | input | 1 | 1 ORs both sum terms into the pin path |
| cfg_reg_out | input | 1 | 1 selects the registered pin output, 0 the combinational one |
| pad | inout | 1 | Three-state device pin |
| pin_in | output | 1 | Level seen on the pin, returned to the array |
| fb | output | 2 | Register feedback to the array |

## Verification
The assertions are sampled on the clock pin and make several assumptions about the inputs:
- The configuration bits do not change across a clock edge.
- A register's clock select changes only while both of its clock candidates are low, so the switch cannot create a false edge.
- Clear, preset and load terms change away from clock edges.
- The pin is driven from outside only while `pt_oe` is low.

The bench follows all of these. It changes inputs two nanoseconds after a rising edge. It switches the clock select to the pin only on a falling edge. It pulses the product-term clocks in the middle of the low-to-high interval of the clock pin. It enables its own pin driver only after it has dropped the enable term.

// File: rtl/pld_cell_pkg.sv
`timescale 1ns/1ps
package pld_cell_pkg;

   typedef enum logic {
      FF_DATA   = 1'b0,
      FF_TOGGLE = 1'b1
   } ff_kind_e;

   typedef enum logic {
      CK_FROM_TERM = 1'b0,
      CK_FROM_PIN  = 1'b1
   } ck_src_e;

   typedef struct packed {
      logic load;
      logic preset;
   } sync_ctl_t;

   function automatic logic ff_update(ff_kind_e kind, logic cur, logic din);
      return (kind == FF_TOGGLE) ? (cur ^ din) : din;
   endfunction

endpackage

// File: rtl/pld_clk_sel.sv
`timescale 1ns/1ps
module pld_clk_sel
   import pld_cell_pkg::*;
(
   input  logic    pin_clk,
   input  logic    term_clk,
   input  ck_src_e src,
   output logic    ck
);

   always_comb begin
      ck = (src == CK_FROM_PIN) ? pin_clk : term_clk;
   end

endmodule

// File: rtl/pld_dt_reg.sv
`timescale 1ns/1ps
module pld_dt_reg
   import pld_cell_pkg::*;
#(
   parameter logic CLEAR_VAL  = 1'b0,
   parameter logic PRESET_VAL = 1'b1
) (
   input  logic      ck,
   input  logic      clr,
   input  ff_kind_e  kind,
   input  logic      din,
   input  sync_ctl_t ctl,
   input  logic      ld_val,
   output logic      q
);

   logic nxt;

   always_comb begin
      if (ctl.load)
         nxt = ld_val;
      else if (ctl.preset)
         nxt = PRESET_VAL;
      else
         nxt = ff_update(kind, q, din);
   end

   always_ff @(posedge ck or posedge clr) begin
      if (clr)
         q <= CLEAR_VAL;
      else
         q <= nxt;
   end

endmodule

// File: rtl/pld_out_sel.sv
`timescale 1ns/1ps
module pld_out_sel #(
   parameter int REG_COUNT = 2
) (
   input  logic                 combined,
   input  logic                 reg_mode,
   input  logic                 s0,
   input  logic                 s1,
   input  logic [REG_COUNT-1:0] q,
   output logic [REG_COUNT-1:0] d,
   output logic                 drive_val
);

   always_comb begin
      d[0]      = combined ? (s0 | s1) : s0;
      d[1]      = s1;
      drive_val = reg_mode ? q[0] : d[0];
   end

endmodule

// File: rtl/pld_macrocell_pair.sv
`timescale 1ns/1ps
module pld_macrocell_pair
   import pld_cell_pkg::*;
#(
   parameter int REG_COUNT = 2
) (
   input  logic                 rst_n,
   input  logic                 clk_pin,
   input  logic [REG_COUNT-1:0] pt_clk,
   input  logic [REG_COUNT-1:0] pt_arst,
   input  logic                 sum0,
   input  logic                 sum1,
   input  logic                 pt_spreset,
   input  logic                 pt_oe,
   input  logic                 preload_en,
   input  logic [REG_COUNT-1:0] preload_val,
   input  logic [REG_COUNT-1:0] cfg_ttype,
   input  logic [REG_COUNT-1:0] cfg_pinclk,
   input  logic                 cfg_combined,
   input  logic                 cfg_reg_out,
   inout  wire                  pad,
   output logic                 pin_in,
   output logic [REG_COUNT-1:0] fb
);

   localparam int SUMS_PER_CELL = 2;

   generate
      if (REG_COUNT != SUMS_PER_CELL) begin : g_bad_count
         $error("pld_macrocell_pair: REG_COUNT must equal the sum terms per cell");
      end
   endgenerate

   logic [REG_COUNT-1:0] d_in;
   logic [REG_COUNT-1:0] q_st;
   logic                 drive_val;
   sync_ctl_t            sctl;

   assign sctl.load   = preload_en;
   assign sctl.preset = pt_spreset;

   pld_out_sel #(.REG_COUNT(REG_COUNT)) u_osel (
      .combined  (cfg_combined),
      .reg_mode  (cfg_reg_out),
      .s0        (sum0),
      .s1        (sum1),
      .q         (q_st),
      .d         (d_in),
      .drive_val (drive_val)
   );

   generate
      for (genvar gi = 0; gi < REG_COUNT; gi++) begin : g_reg
         logic ck_i;
         logic clr_i;

         assign clr_i = pt_arst[gi] | ~rst_n;

         pld_clk_sel u_cks (
            .pin_clk  (clk_pin),
            .term_clk (pt_clk[gi]),
            .src      (ck_src_e'(cfg_pinclk[gi])),
            .ck       (ck_i)
         );

         pld_dt_reg #(.CLEAR_VAL(1'b0), .PRESET_VAL(1'b1)) u_ff (
            .ck     (ck_i),
            .clr    (clr_i),
            .kind   (ff_kind_e'(cfg_ttype[gi])),
            .din    (d_in[gi]),
            .ctl    (sctl),
            .ld_val (preload_val[gi]),
            .q      (q_st[gi])
         );
      end
   endgenerate

   assign fb     = q_st;
   assign pad    = pt_oe ? drive_val : 1'bz;
   assign pin_in = pad;

endmodule

// File: rtl/pld_macrocell_pair_chk.sv
`timescale 1ns/1ps
module pld_macrocell_pair_chk #(
   parameter int REG_COUNT = 2
) (
   input logic                 rst_n,
   input logic                 clk_pin,
   input logic [REG_COUNT-1:0] pt_arst,
   input logic                 sum1,
   input logic                 pt_spreset,
   input logic                 pt_oe,
   input logic                 preload_en,
   input logic [REG_COUNT-1:0] preload_val,
   input logic [REG_COUNT-1:0] cfg_ttype,
   input logic [REG_COUNT-1:0] cfg_pinclk,
   input logic                 cfg_reg_out,
   input logic                 pin_in,
   input logic [REG_COUNT-1:0] fb
);

   generate
      for (genvar gi = 0; gi < REG_COUNT; gi++) begin : g_chk
         // R4: a held clear keeps the feedback low
         a_r4_clear_holds: assert property (@(posedge clk_pin) disable iff (!rst_n)
            pt_arst[gi] |-> !fb[gi]);

         // R5: preset on a pin-clocked register
         a_r5_preset_loads: assert property (@(posedge clk_pin)
            disable iff (!rst_n || pt_arst[gi])
            (cfg_pinclk[gi] && pt_spreset && !preload_en) |=> fb[gi]);

         // R6: test load wins over preset and update
         a_r6_preload_wins: assert property (@(posedge clk_pin)
            disable iff (!rst_n || pt_arst[gi])
            (cfg_pinclk[gi] && preload_en) |=> (fb[gi] == $past(preload_val[gi])));
      end
   endgenerate

   // R2: register 1 in toggle mode with its data input at 1
   a_r2_toggle_flips: assert property (@(posedge clk_pin)
      disable iff (!rst_n || pt_arst[1])
      (cfg_pinclk[1] && cfg_ttype[1] && sum1 && !pt_spreset && !preload_en)
      |=> (fb[1] != $past(fb[1])));

   // R7: registered pin output mirrors the feedback of register 0
   a_r7_pad_registered: assert property (@(posedge clk_pin) disable iff (!rst_n)
      (pt_oe && cfg_reg_out) |-> (pin_in == fb[0]));

endmodule

bind pld_macrocell_pair pld_macrocell_pair_chk #(.REG_COUNT(REG_COUNT)) u_chk (
   .rst_n       (rst_n),
   .clk_pin     (clk_pin),
   .pt_arst     (pt_arst),
   .sum1        (sum1),
   .pt_spreset  (pt_spreset),
   .pt_oe       (pt_oe),
   .preload_en  (preload_en),
   .preload_val (preload_val),
   .cfg_ttype   (cfg_ttype),
   .cfg_pinclk  (cfg_pinclk),
   .cfg_reg_out (cfg_reg_out),
   .pin_in      (pin_in),
   .fb          (fb)
);

// File: tb/pld_macrocell_pair_test.sv
`timescale 1ns/1ps
module pld_macrocell_pair_test;

   logic       rst_n = 1'b0;
   logic       clk_pin = 1'b0;
   logic [1:0] pt_clk = '0;
   logic [1:0] pt_arst = '0;
   logic       sum0 = 1'b0, sum1 = 1'b0;
   logic       pt_spreset = 1'b0, pt_oe = 1'b0, preload_en = 1'b0;
   logic [1:0] preload_val = '0, cfg_ttype = '0, cfg_pinclk = 2'b11;
   logic       cfg_combined = 1'b0, cfg_reg_out = 1'b0;
   logic       drv_en = 1'b0, drv_val = 1'b0;
   wire        pad;
   logic       pin_in;
   logic [1:0] fb;

   int         n_chk = 0, n_err = 0;
   logic [1:0] mq = '0;
   bit         done = 1'b0;

   assign pad = drv_en ? drv_val : 1'bz;

   always #5 clk_pin = ~clk_pin;

   pld_macrocell_pair uut (
      .rst_n(rst_n), .clk_pin(clk_pin), .pt_clk(pt_clk), .pt_arst(pt_arst),
      .sum0(sum0), .sum1(sum1), .pt_spreset(pt_spreset), .pt_oe(pt_oe),
      .preload_en(preload_en), .preload_val(preload_val), .cfg_ttype(cfg_ttype),
      .cfg_pinclk(cfg_pinclk), .cfg_combined(cfg_combined), .cfg_reg_out(cfg_reg_out),
      .pad(pad), .pin_in(pin_in), .fb(fb)
   );

   task automatic chk(string tag, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
      end
   endtask

   function automatic logic d_of(int i);
      if (i == 0) return cfg_combined ? (sum0 | sum1) : sum0;
      return sum1;
   endfunction

   function automatic logic model_next(int i);
      if (preload_en) return preload_val[i];
      if (pt_spreset) return 1'b1;
      if (cfg_ttype[i]) return mq[i] ^ d_of(i);
      return d_of(i);
   endfunction

   function automatic string tag_of(int i);
      if (preload_en) return "R6";
      if (pt_spreset) return "R5";
      if (cfg_ttype[i]) return "R2";
      return "R1";
   endfunction

   task automatic pin_cycle();
      logic [1:0] nx;
      for (int i = 0; i < 2; i++) nx[i] = model_next(i);
      @(posedge clk_pin);
      #2;
      mq = nx;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk_pin);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk_pin);
      #2;
      chk("R4 clear in reset fb0", fb[0], 1'b0);
      chk("R4 clear in reset fb1", fb[1], 1'b0);
      @(negedge clk_pin);
      rst_n = 1'b1;
      @(posedge clk_pin);
      #2;
      chk("R9 power-up fb0", fb[0], 1'b0);
      chk("R9 power-up fb1", fb[1], 1'b0);
      mq = '0;

      // R1 R2 R5 R6 R7: sweep every mode against every input pattern
      pt_oe = 1'b1;
      for (int c = 0; c < 16; c++) begin
         cfg_ttype    = c[1:0];
         cfg_combined = c[2];
         cfg_reg_out  = c[3];
         for (int v = 0; v < 64; v++) begin
            {preload_val, preload_en, pt_spreset, sum1, sum0} = v[5:0];
            pin_cycle();
            for (int i = 0; i < 2; i++) chk(tag_of(i), fb[i], mq[i]);
            chk("R7 driven pin", pin_in, cfg_reg_out ? mq[0] : d_of(0));
         end
      end

      // R3: product-term clocks
      preload_en = 1'b1; preload_val = 2'b00; pt_spreset = 1'b0;
      pin_cycle();
      chk("R6 clear by load", fb[0] | fb[1], 1'b0);
      cfg_pinclk = 2'b00; preload_en = 1'b0; cfg_ttype = 2'b00;
      cfg_combined = 1'b1; sum0 = 1'b1; sum1 = 1'b1;
      repeat (2) @(posedge clk_pin);
      #2;
      chk("R3 pin clock ignored fb0", fb[0], 1'b0);
      chk("R3 pin clock ignored fb1", fb[1], 1'b0);
      pt_clk[1] = 1'b1; #1 pt_clk[1] = 1'b0; #1;
      chk("R3 term clock 1 fb1", fb[1], 1'b1);
      chk("R3 term clock 1 leaves fb0", fb[0], 1'b0);
      pt_clk[0] = 1'b1; #1 pt_clk[0] = 1'b0; #1;
      chk("R3 term clock 0 fb0", fb[0], 1'b1);
      @(negedge clk_pin);
      cfg_pinclk = 2'b11;
      mq = 2'b11;

      // R4: asynchronous clear and its priority
      @(posedge clk_pin);
      #2;
      pt_arst = 2'b01;
      #1;
      chk("R4 async clear fb0", fb[0], 1'b0);
      chk("R4 other reg kept", fb[1], 1'b1);
      preload_en = 1'b1; preload_val = 2'b11;
      @(posedge clk_pin);
      #2;
      chk("R4 clear beats load", fb[0], 1'b0);
      chk("R6 load on reg1", fb[1], 1'b1);
      pt_arst = 2'b00; preload_en = 1'b0;
      mq = 2'b10;
      pin_cycle();
      chk("R1 after clear fb0", fb[0], mq[0]);
      chk("R1 after clear fb1", fb[1], mq[1]);
      rst_n = 1'b0;
      #1;
      chk("R4 power clear fb", fb[0] | fb[1], 1'b0);
      rst_n = 1'b1;
      mq = 2'b00;

      // R7 R8: pin as input, feedback stays internal
      preload_en = 1'b1; preload_val = 2'b01; cfg_reg_out = 1'b1;
      pin_cycle();
      chk("R6 load fb0", fb[0], 1'b1);
      pt_oe = 1'b0;
      #1;
      drv_en = 1'b1; drv_val = 1'b0;
      #1;
      chk("R7 pin reads external 0", pin_in, 1'b0);
      chk("R8 fb0 kept while pin low", fb[0], 1'b1);
      pin_cycle();
      chk("R8 fb0 after edge", fb[0], mq[0]);
      drv_val = 1'b1;
      #1;
      chk("R7 pin reads external 1", pin_in, 1'b1);
      preload_en = 1'b0; cfg_ttype = 2'b10; cfg_combined = 1'b0;
      sum0 = 1'b0; sum1 = 1'b1;
      pin_cycle();
      chk("R8 buried toggle fb1", fb[1], mq[1]);
      chk("R8 fb0 follows sum0", fb[0], mq[0]);
      pin_cycle();
      chk("R2 buried toggle again", fb[1], mq[1]);
      drv_en = 1'b0;
      #1;
      pt_oe = 1'b1;
      #1;
      chk("R7 re-enabled pin", pin_in, fb[0]);

      finish_run();
   end

endmodule